// File: doc/BRIEF.md
# Thermometer-Pattern Chain Connectivity Sequencer

This block sits on the tester side of a board-level connectivity test. It drives the inputs of one parity-style test chain, in which every chain input feeds an XOR stage and the first stage is tied high. It then judges the single chain output that comes back. After a start pulse it steps through N+1 thermometer-coded vectors. The first vector is all zeros, and each later vector raises one more input, beginning at bit 0, until every input is high.

For every vector the block first drives the pattern. It then waits a fixed number of settle cycles, samples the chain output, and compares the sample with the expected value. On a healthy board the expected value is 1 for even vector numbers and 0 for odd ones. A pin shorted high or floating high shows up as a mismatch on the earliest vectors. A pin stuck low shows up starting at the vector that first raises it. The block keeps a sticky fail flag and the number of the first vector that mismatched, and it pulses done once the run ends.

All pins are plain control and status signals. The block has no streaming interface, so valid/ready and back-pressure do not apply. A start pulse that arrives while a run is active is dropped.

Top module: `chain_walk_checker`

## Requirements
- R1: Right after reset, the vector output is all zeros, done is 0, the fail flag is 0 and the failing-index output is 0.
- R2: A start pulse seen while idle begins a run and clears the fail flag and the failing index. Vector 0 (all zeros) is driven in the first cycle after the accepting edge.
- R3: Vector k (0 ≤ k ≤ N) has exactly bits k-1 down to 0 set, bit 0 being the first input raised. A run therefore covers N+1 vectors, and the vector output is all zeros whenever the block is idle.
- R4: Each vector is held for SETTLE_CYCLES+2 cycles: one apply cycle, SETTLE_CYCLES settle cycles (at least 1), then one sample cycle. The chain input is captured at the clock edge that ends the sample cycle.
- R5: The expected chain value for vector k is 1 when k is even and 0 when k is odd. Any mismatch sets the fail flag, which stays set until the next accepted start. It becomes visible in the cycle after the sample edge.
- R6: The failing-index output holds the number of the first mismatching vector of the run, and nothing changes it until the next accepted start. It reads 0 when the run has no mismatch.
- R7: done is high for exactly one cycle, (N+1)·(SETTLE_CYCLES+2) cycles after the accepting edge. The vector output still shows vector N during that cycle and is all zeros afterwards.
- R8: start is ignored while a run is in progress, including the done cycle. Such a pulse does not restart, stretch or disturb the run.
- R9: On a chain where input j is stuck high, the first failing index is 0. Where input j is stuck low, it is j+1. On a fault-free chain the fail flag stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Run request, accepted only while idle |
| vec_o | output | N_INPUTS | Pattern driven onto the chain inputs |
| chain_i | input | 1 | Sampled chain output |
| done_o | output | 1 | One-cycle end-of-run pulse |
| fail_o | output | 1 | Sticky mismatch flag |
| fail_idx_o | output | $clog2(N_INPUTS+1) | First mismatching vector number |

## Verification
With an accepting edge at cycle 0, vector k is on the output from cycle k·(SETTLE_CYCLES+2)+1 and is sampled at the edge ending cycle (k+1)·(SETTLE_CYCLES+2). A mismatch reaches the fail flag and the index one cycle after that edge, and done appears (N+1)·(SETTLE_CYCLES+2) cycles after acceptance. The bench keeps a behavioural timeline built on these counts. Its chain model is driven by the live vector, with optional stuck-high or stuck-low faults. Every output is compared with the timeline at each falling edge, so a response that comes a cycle early or late is a mismatch.

// File: rtl/cwc_pkg.sv
package cwc_pkg;
  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_APPLY  = 3'd1,
    ST_SETTLE = 3'd2,
    ST_SAMPLE = 3'd3,
    ST_DONE   = 3'd4
  } cwc_state_e;
endpackage

// File: rtl/cwc_thermo_reg.sv
module cwc_thermo_reg #(
  parameter int N_INPUTS = 6
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                clear_i,
  input  logic                advance_i,
  output logic [N_INPUTS-1:0] vec_o
);
  localparam logic [N_INPUTS-1:0] LSB_ONE = N_INPUTS'(1);

  logic [N_INPUTS-1:0] vec_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         vec_q <= '0;
    else if (clear_i)   vec_q <= '0;
    else if (advance_i) vec_q <= (vec_q << 1) | LSB_ONE;
  end

  assign vec_o = vec_q;

  // R3: the register only ever holds a thermometer code filled from bit 0
  a_r3_thermo_shape: assert property (@(posedge clk) disable iff (!rst_n)
    ((vec_q + LSB_ONE) & vec_q) == '0);
endmodule

// File: rtl/cwc_settle_timer.sv
module cwc_settle_timer #(
  parameter int SETTLE_CYCLES = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load_i,
  input  logic run_i,
  output logic expired_o
);
  localparam int CW = (SETTLE_CYCLES > 1) ? $clog2(SETTLE_CYCLES) : 1;
  localparam logic [CW-1:0] RELOAD = CW'(SETTLE_CYCLES - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     cnt_q <= '0;
    else if (load_i)                cnt_q <= RELOAD;
    else if (run_i && cnt_q != '0)  cnt_q <= cnt_q - CW'(1);
  end

  assign expired_o = (cnt_q == '0);

  // R4: the count never rises except on a reload
  a_r4_timer_down: assert property (@(posedge clk) disable iff (!rst_n)
    !load_i |=> cnt_q <= $past(cnt_q));
endmodule

// File: rtl/cwc_verdict.sv
module cwc_verdict #(
  parameter int IW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear_i,
  input  logic          sample_i,
  input  logic          observed_i,
  input  logic          expected_i,
  input  logic [IW-1:0] step_i,
  output logic          fail_o,
  output logic [IW-1:0] fail_idx_o
);
  logic          fail_q;
  logic [IW-1:0] idx_q;
  logic          mismatch;

  assign mismatch = sample_i && (observed_i != expected_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fail_q <= 1'b0;
      idx_q  <= '0;
    end else if (clear_i) begin
      fail_q <= 1'b0;
      idx_q  <= '0;
    end else if (mismatch && !fail_q) begin
      fail_q <= 1'b1;
      idx_q  <= step_i;
    end
  end

  assign fail_o     = fail_q;
  assign fail_idx_o = idx_q;

  // R5: once set, the flag stays until a clear
  a_r5_fail_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (fail_q && !clear_i) |=> fail_q);
  // R6: the first index is frozen after capture
  a_r6_idx_held: assert property (@(posedge clk) disable iff (!rst_n)
    (fail_q && !clear_i) |=> $stable(idx_q));
  // R6: without a failure the index reads zero
  a_r6_idx_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !fail_q |-> idx_q == '0);
endmodule

// File: rtl/chain_walk_checker.sv
module chain_walk_checker #(
  parameter int N_INPUTS      = 6,
  parameter int SETTLE_CYCLES = 3,
  localparam int IW           = $clog2(N_INPUTS + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start_i,
  output logic [N_INPUTS-1:0] vec_o,
  input  logic                chain_i,
  output logic                done_o,
  output logic                fail_o,
  output logic [IW-1:0]       fail_idx_o
);
  import cwc_pkg::*;

  localparam logic [IW-1:0] LAST_STEP = IW'(N_INPUTS);

  cwc_state_e    state_q;
  logic [IW-1:0] step_q;
  logic          accept;
  logic          expired;
  logic          in_sample;
  logic          last_step;
  logic          vec_clear;
  logic          vec_advance;

  assign accept      = (state_q == ST_IDLE) && start_i;
  assign in_sample   = (state_q == ST_SAMPLE);
  assign last_step   = (step_q == LAST_STEP);
  assign vec_clear   = (state_q == ST_IDLE) || (state_q == ST_DONE);
  assign vec_advance = in_sample && !last_step;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      step_q  <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (start_i) begin
          state_q <= ST_APPLY;
          step_q  <= '0;
        end
        ST_APPLY:  state_q <= ST_SETTLE;
        ST_SETTLE: if (expired) state_q <= ST_SAMPLE;
        ST_SAMPLE: begin
          if (last_step) state_q <= ST_DONE;
          else begin
            state_q <= ST_APPLY;
            step_q  <= step_q + IW'(1);
          end
        end
        ST_DONE:   state_q <= ST_IDLE;
        default:   state_q <= ST_IDLE;
      endcase
    end
  end

  cwc_thermo_reg #(.N_INPUTS(N_INPUTS)) u_pattern (
    .clk       (clk),
    .rst_n     (rst_n),
    .clear_i   (vec_clear),
    .advance_i (vec_advance),
    .vec_o     (vec_o)
  );

  cwc_settle_timer #(.SETTLE_CYCLES(SETTLE_CYCLES)) u_settle (
    .clk       (clk),
    .rst_n     (rst_n),
    .load_i    (state_q == ST_APPLY),
    .run_i     (state_q == ST_SETTLE),
    .expired_o (expired)
  );

  cwc_verdict #(.IW(IW)) u_verdict (
    .clk        (clk),
    .rst_n      (rst_n),
    .clear_i    (accept),
    .sample_i   (in_sample),
    .observed_i (chain_i),
    .expected_i (~step_q[0]),
    .step_i     (step_q),
    .fail_o     (fail_o),
    .fail_idx_o (fail_idx_o)
  );

  assign done_o = (state_q == ST_DONE);

  // R3: vector k carries exactly k ones while it is applied
  a_r3_ones_match_step: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_APPLY) |-> $countones(vec_o) == int'(step_q));
  // R3: idle means an all-zero pattern
  a_r3_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IDLE) |-> vec_o == '0);
  // R7: done is a single-cycle pulse
  a_r7_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);
  // R8: a run in progress cannot fall back to idle before done
  a_r8_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q != ST_IDLE && state_q != ST_DONE) |=> state_q != ST_IDLE);
  // R2: accepted start clears the verdict
  a_r2_clear_on_start: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> (!fail_o && fail_idx_o == '0 && vec_o == '0));
  // R4: a vector is never changed during settle
  a_r4_hold_in_settle: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_SETTLE) |=> $stable(vec_o));
endmodule

// File: tb/tb_chain_walk_checker.sv
`timescale 1ns/1ps
module tb_chain_walk_checker;
  localparam int N  = 6;
  localparam int S  = 3;
  localparam int IW = $clog2(N + 1);
  localparam int P  = S + 2;
  localparam int D  = (N + 1) * P;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start_i = 1'b0;
  logic [N-1:0]  vec_o;
  logic          chain_i;
  logic          done_o;
  logic          fail_o;
  logic [IW-1:0] fail_idx_o;

  int tests = 0;
  int fails = 0;
  int cyc = 0;
  bit finished = 0;

  int fault_mode = 0;   // 0 none, 1 stuck high, 2 stuck low
  int fault_pin  = 0;

  // reference timeline
  bit m_run = 0;
  int m_t = 0;
  bit m_fail = 0;
  int m_idx = 0;

  always #4 clk = ~clk;

  chain_walk_checker #(.N_INPUTS(N), .SETTLE_CYCLES(S)) dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .vec_o(vec_o),
    .chain_i(chain_i), .done_o(done_o), .fail_o(fail_o), .fail_idx_o(fail_idx_o)
  );

  function automatic logic board(input logic [N-1:0] v);
    logic [N-1:0] p;
    p = v;
    if (fault_mode == 1) p[fault_pin] = 1'b1;
    if (fault_mode == 2) p[fault_pin] = 1'b0;
    return 1'b1 ^ (^p);
  endfunction

  function automatic logic [N-1:0] thermo(input int k);
    logic [N-1:0] r;
    r = '0;
    for (int i = 0; i < N; i++) if (i < k) r[i] = 1'b1;
    return r;
  endfunction

  assign chain_i = board(vec_o);

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s at cycle %0d: actual %0d expected %0d", tag, cyc, act, exp);
    end
  endtask

  // behavioural reference, advanced at each rising edge
  always @(posedge clk) begin
    cyc++;
    if (!rst_n) begin
      m_run = 0; m_t = 0; m_fail = 0; m_idx = 0;
    end else if (!m_run) begin
      if (start_i) begin   // R2 accept
        m_run = 1; m_t = 0; m_fail = 0; m_idx = 0;
      end
    end else begin
      if (m_t < D && (m_t % P) == P - 1) begin
        int k;
        k = m_t / P;
        if (board(thermo(k)) != ((k % 2) == 0) && !m_fail) begin
          m_fail = 1; m_idx = k;
        end
      end
      m_t++;
      if (m_t > D) m_run = 0;   // R8: start during the run is not looked at
    end
  end

  // compare on every falling edge
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      logic [N-1:0] ev;
      bit ed;
      ev = '0; ed = 0;
      if (m_run && m_t < D) ev = thermo(m_t / P);
      else if (m_run && m_t == D) begin ev = thermo(N); ed = 1; end
      chk(vec_o == ev, "R3/R4 vector", int'(vec_o), int'(ev));
      chk(done_o == ed, "R7 done", int'(done_o), int'(ed));
      chk(fail_o == m_fail, "R5 fail", int'(fail_o), int'(m_fail));
      chk(int'(fail_idx_o) == m_idx, "R6 index", int'(fail_idx_o), m_idx);
    end
  end

  always @(posedge clk) begin
    if (cyc > 150000 && !finished) begin
      finished = 1;
      fails++;
      tests++;
      $display("FAIL watchdog expired: actual %0d expected %0d", cyc, 150000);
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  task automatic run_one(input int mode, input int pin, input bit poke_busy);
    fault_mode = mode;
    fault_pin  = pin;
    @(negedge clk);
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    // R2: cleared verdict and zero vector in first cycle of the run
    chk(fail_o == 1'b0, "R2 fail cleared", int'(fail_o), 0);
    chk(vec_o == '0, "R2 first vector", int'(vec_o), 0);
    if (poke_busy) begin
      repeat (7) @(negedge clk);
      start_i = 1'b1;   // R8 mid-run pulse
      repeat (3) @(negedge clk);
      start_i = 1'b0;
    end
    while (!done_o) @(negedge clk);
    if (poke_busy) start_i = 1'b1;   // R8 pulse in the done cycle
    @(negedge clk);
    start_i = 1'b0;
    // R9 closed-form localisation
    if (mode == 0) chk(fail_o == 1'b0, "R9 good board", int'(fail_o), 0);
    if (mode == 1) chk(fail_o && fail_idx_o == 0, "R9 stuck high", int'(fail_idx_o), 0);
    if (mode == 2) chk(fail_o && int'(fail_idx_o) == pin + 1, "R9 stuck low",
                       int'(fail_idx_o), pin + 1);
    repeat (4) @(negedge clk);
    // R6: verdict still held while idle
    if (mode == 2) chk(int'(fail_idx_o) == pin + 1, "R6 held idle", int'(fail_idx_o), pin + 1);
    chk(done_o == 1'b0, "R8 no second run", int'(done_o), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(vec_o == '0, "R1 vector", int'(vec_o), 0);
    chk(done_o == 1'b0, "R1 done", int'(done_o), 0);
    chk(fail_o == 1'b0, "R1 fail", int'(fail_o), 0);
    chk(fail_idx_o == '0, "R1 index", int'(fail_idx_o), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    run_one(0, 0, 0);
    run_one(1, 2, 0);
    run_one(2, 4, 0);
    run_one(0, 0, 1);
    run_one(2, N - 1, 0);
    run_one(1, N - 1, 1);
    run_one(2, 0, 0);
    run_one(0, 0, 0);
    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule